// File: doc/BRIEF.md
# Processor I/O Port with Bank Decoder

This block places an 8-bit bidirectional port at the two lowest CPU addresses and pairs it with a memory-map decoder. Address `$0000` holds a direction register, where a 1 makes a pin an output and a 0 makes it an input. Address `$0001` holds the data latch. Each pin drives the latched value, and the direction bit enables that drive. Each pin also has an input level and an input that shows whether something outside drives it. A pin left undriven reads as 1, as it would through a pull-up.

The effective levels of port bits 0, 1 and 2 steer the region decoder. Bit 0 turns on the BASIC ROM at `$A000`–`$BFFF`. Bit 1 turns on the KERNAL ROM at `$E000`–`$FFFF`. Bit 2 chooses, for the `$D000`–`$DFFF` window, between the I/O space (bit 2 = 1) and the character ROM (bit 2 = 0). Bits 3 and 5 drive the cassette data line and the cassette motor, and bit 4 senses the cassette switch. The decoder produces one-hot region selects, and on a write cycle it always selects RAM. A read of `$0000` or `$0001` raises `port_hit`, which tells the system read multiplexer to take `port_rdata` instead of memory.

Top module: `port_bank_map`

## Requirements
- R1: After reset the direction register holds `8'h2F` (`pin_oe` = `8'h2F`) and the data latch holds `8'h37` (`pin_out` = `8'h37`).
- R2: A write cycle to address `16'h0000` loads `cpu_wdata` into the direction register, and `pin_oe` shows it from the next clock. No other write changes `pin_oe`.
- R3: A write cycle to address `16'h0001` loads `cpu_wdata` into the data latch, and `pin_out` shows it from the next clock. No other write changes `pin_out`.
- R4: `port_hit` is 1 exactly when `cpu_addr` is `16'h0000` or `16'h0001`. At `16'h0000`, `port_rdata` is the direction register.
- R5: At `16'h0001`, `port_rdata` bit i is the latched bit where direction bit i is 1. Where direction bit i is 0, it is the pin level: `pin_in[i]` if `pin_driven[i]` is 1, otherwise 1.
- R6: On a read, an address in `$A000`–`$BFFF` selects BASIC ROM when the effective level of port bit 0 is 1, and selects RAM when it is 0.
- R7: On a read, an address in `$E000`–`$FFFF` selects KERNAL ROM when the effective level of port bit 1 is 1, and selects RAM when it is 0.
- R8: On a read, an address in `$D000`–`$DFFF` selects I/O when the effective level of port bit 2 is 1, and selects character ROM when it is 0.
- R9: On a read, every other address selects RAM. Exactly one of the five selects is 1 at all times.
- R10: While `cpu_we` is 1, only `sel_ram` is 1, whatever the address, including `$0000`/`$0001` and the ROM ranges.
- R11: The decoder uses the effective level from R5, not the latch. A port bit set as an input follows its pin, and reads as 1 when the pin is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe |
| port_rdata | output | 8 | Read value of the port register at the address |
| port_hit | output | 1 | Address is one of the two port registers |
| pin_in | input | 8 | Level seen on each port pin |
| pin_driven | input | 8 | 1 where something outside drives the pin |
| pin_out | output | 8 | Value each pin drives |
| pin_oe | output | 8 | Per-pin output enable |
| sel_ram | output | 1 | RAM selected |
| sel_basic | output | 1 | BASIC ROM selected |
| sel_kernal | output | 1 | KERNAL ROM selected |
| sel_char | output | 1 | Character ROM selected |
| sel_io | output | 1 | I/O space selected |

## Verification
The decoder is tried with four port values: the reset value `$37`, the RAM-heavy value `$34`, `$33`, which brings in the character ROM, and a case with bit 0 turned into an input. With the three written values, ROM on and ROM off are each seen in every window. The last case shows that the decoder follows the pin level, the pull-up or an external low, and not the latch. Reads are checked with the input pins undriven and then driven with a mixed pattern, which separates latch bits from pin bits. Writes to the ROM windows and to a neighbouring address show that RAM wins on writes and that the registers stay unchanged.

// File: rtl/port_bank_map.sv
module port_bank_map #(
  parameter logic [7:0] DIR_RESET  = 8'h2F,
  parameter logic [7:0] DATA_RESET = 8'h37
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  output logic [7:0]  port_rdata,
  output logic        port_hit,
  input  logic [7:0]  pin_in,
  input  logic [7:0]  pin_driven,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  output logic        sel_ram,
  output logic        sel_basic,
  output logic        sel_kernal,
  output logic        sel_char,
  output logic        sel_io
);

  logic [7:0] dir_q, dat_q, ext_lvl, lvl;
  logic in_basic, in_kern, in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RESET;
      dat_q <= DATA_RESET;
    end else if (cpu_we && cpu_addr[15:1] == 15'd0) begin
      if (cpu_addr[0]) dat_q <= cpu_wdata;
      else             dir_q <= cpu_wdata;
    end
  end

  assign ext_lvl = (pin_in & pin_driven) | ~pin_driven;
  assign lvl     = (dat_q & dir_q) | (ext_lvl & ~dir_q);

  assign pin_out    = dat_q;
  assign pin_oe     = dir_q;
  assign port_hit   = cpu_addr[15:1] == 15'd0;
  assign port_rdata = cpu_addr[0] ? lvl : dir_q;

  assign in_basic = cpu_addr[15:13] == 3'b101;
  assign in_kern  = cpu_addr[15:13] == 3'b111;
  assign in_win   = cpu_addr[15:12] == 4'hD;

  assign sel_basic  = !cpu_we && in_basic && lvl[0];
  assign sel_kernal = !cpu_we && in_kern  && lvl[1];
  assign sel_io     = !cpu_we && in_win   && lvl[2];
  assign sel_char   = !cpu_we && in_win   && !lvl[2];
  assign sel_ram    = !(sel_basic || sel_kernal || sel_io || sel_char);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_ram, sel_basic, sel_kernal, sel_char, sel_io})); // R9
  AST_WRITE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |-> sel_ram); // R10
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h0000) |=> pin_oe == $past(cpu_wdata)); // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h0001) |=> pin_out == $past(cpu_wdata)); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr[15:1] == 15'd0) |=> $stable(pin_oe) && $stable(pin_out)); // R2
  AST_WIN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && in_win) |-> (sel_io || sel_char)); // R8

endmodule

// File: tb/port_bank_map_test.sv
module port_bank_map_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0] cpu_wdata = 0, pin_in = 0, pin_driven = 0;
  logic cpu_we = 0;
  logic [7:0] port_rdata, pin_out, pin_oe;
  logic port_hit, sel_ram, sel_basic, sel_kernal, sel_char, sel_io;
  int checks = 0, errors = 0;

  localparam logic [4:0] S_RAM = 5'b10000, S_BAS = 5'b01000, S_KER = 5'b00100,
                         S_CHR = 5'b00010, S_IO = 5'b00001;

  port_bank_map uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    @(posedge clk); #1;
    cpu_we = 0;
  endtask

  task automatic rd_sel(string req, logic [15:0] a, logic [4:0] exp);
    @(negedge clk);
    cpu_addr = a; #1;
    chk(req, {11'd0, sel_ram, sel_basic, sel_kernal, sel_char, sel_io}, {11'd0, exp});
  endtask

  task automatic rd_port(string req, logic [15:0] a, logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; #1;
    chk(req, {8'd0, port_rdata}, {8'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 dir", {8'd0, pin_oe}, 16'h002F);
    chk("R1 data", {8'd0, pin_out}, 16'h0037);
    rd_port("R4 read dir", 16'h0000, 8'h2F);
    rd_port("R5 read data pull-up", 16'h0001, 8'hF7);
    chk("R4 hit", {15'd0, port_hit}, 16'd1);
  endtask

  task automatic t_normal_map;
    rd_sel("R6 basic on", 16'hA123, S_BAS);
    rd_sel("R6 basic top", 16'hBFFF, S_BAS);
    rd_sel("R7 kernal on", 16'hE000, S_KER);
    rd_sel("R8 io window", 16'hD400, S_IO);
    rd_sel("R9 ram 8000", 16'h8000, S_RAM);
    rd_sel("R9 ram C000", 16'hC000, S_RAM);
    @(negedge clk); cpu_addr = 16'h0002; #1;
    chk("R4 no hit 0002", {15'd0, port_hit}, 16'd0);
  endtask

  task automatic t_ram_heavy;
    wr(16'h0001, 8'h34);
    chk("R3 data write", {8'd0, pin_out}, 16'h0034);
    rd_sel("R6 basic off", 16'hA000, S_RAM);
    rd_sel("R7 kernal off", 16'hFFFF, S_RAM);
    rd_sel("R8 io kept", 16'hD000, S_IO);
    rd_port("R5 read mixed", 16'h0001, 8'hF4);
  endtask

  task automatic t_char;
    wr(16'h0001, 8'h33);
    rd_sel("R8 char rom", 16'hD800, S_CHR);
    rd_sel("R6 basic back", 16'hA000, S_BAS);
    rd_sel("R7 kernal back", 16'hE000, S_KER);
  endtask

  task automatic t_input_bit;
    wr(16'h0001, 8'h34);
    wr(16'h0000, 8'h2E);
    chk("R2 dir write", {8'd0, pin_oe}, 16'h002E);
    rd_port("R4 read new dir", 16'h0000, 8'h2E);
    rd_sel("R11 pull-up basic", 16'hA000, S_BAS);
    pin_driven = 8'h01; pin_in = 8'h00;
    rd_sel("R11 driven low", 16'hA000, S_RAM);
    pin_driven = 8'hFF; pin_in = 8'hA5;
    rd_port("R5 driven inputs", 16'h0001, (8'h34 & 8'h2E) | (8'hA5 & ~8'h2E));
    pin_driven = 8'h00;
  endtask

  task automatic t_write_ram;
    wr(16'h0000, 8'h2F);
    wr(16'h0001, 8'h37);
    foreach (cpu_addr[i]) begin end
    @(negedge clk);
    cpu_addr = 16'hA000; cpu_wdata = 8'h00; cpu_we = 1; #1;
    chk("R10 write basic range", {11'd0, sel_ram, sel_basic, sel_kernal, sel_char, sel_io}, {11'd0, S_RAM});
    cpu_addr = 16'hD000; #1;
    chk("R10 write io range", {11'd0, sel_ram, sel_basic, sel_kernal, sel_char, sel_io}, {11'd0, S_RAM});
    cpu_addr = 16'h0001; cpu_wdata = 8'h37; #1;
    chk("R10 write port addr", {11'd0, sel_ram, sel_basic, sel_kernal, sel_char, sel_io}, {11'd0, S_RAM});
    @(posedge clk); #1; cpu_we = 0;
    wr(16'h0002, 8'h00);
    wr(16'hD000, 8'h00);
    chk("R2 no change dir", {8'd0, pin_oe}, 16'h002F);
    chk("R3 no change data", {8'd0, pin_out}, 16'h0037);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_normal_map;
    t_ram_heavy;
    t_char;
    t_input_bit;
    t_write_ram;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule